// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces up to four independent pulse-width-modulated outputs from one input clock. Software configures each channel through a small word-addressed register bus: a control word with a run bit and a clock prescaler, a high-time count and a cycle-length count. Each channel divides the clock by its prescaler plus one to form a counting tick. It counts ticks around the programmed cycle length and holds its output high for the programmed number of ticks at the start of each cycle.

A build option adds a global gate register. When the option is on, a channel runs only while both the gate and its own run bit are set. Configuration changes made while a channel is running are held back until the current cycle ends, so a pulse is never cut short or stretched part-way through.

Top module: `pwm_bank_top`

## Requirements
- R1: Channel k occupies byte addresses k*16 to k*16+15. Offset 0x0 is control, with the run bit in bit 0 and a 14-bit prescaler in bits [15:2]. Offset 0x4 is the 16-bit high-time count and offset 0x8 is the 16-bit cycle-length count. Reads return exactly the stored bits and zero elsewhere, so a read-modify-write of control keeps the prescaler.
- R2: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high. After any cycle without a read, `bus_rdata` is zero.
- R3: Offset 0xC of a channel window (other than the gate address), addresses at or above NUM_CH*16 (other than the gate address), and addresses that are not word aligned all read as zero. Writes to any of them change no register.
- R4: A running channel with prescaler p, high count d and cycle count n (0 < d < n) repeats a cycle of (p+1)*n clocks. Its output is high for the first (p+1)*d clocks of each cycle.
- R5: When the high count is greater than or equal to a nonzero cycle count, the output stays high continuously. A cycle count of zero, or a high count of zero, keeps the output low.
- R6: While a channel is not running, its output is low. When it starts running, its output goes high on the clock after the start and begins a fresh cycle.
- R7: New prescaler, high-count and cycle-count values take effect only at the end of the cycle in progress.
- R8: With the gate option built in, address 0x3C bit 0 is the global gate, readable and writable. While the gate is clear, all outputs are low.
- R9: Reset clears every register, including the gate, and holds every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W (32) | Registered read data, valid one cycle after the strobe |
| pwm_out | output | NUM_CH (4) | One modulated output per channel |

## Verification
A wrong prescaler or tick count shows at the output as a high time or cycle length that misses its exact clock count by the first full cycle. A loose shadow-load path shows as a pulse that changes width in the middle of a cycle, within the cycle in which the write lands. A stuck start flag shows as an output that is not high on the clock after enabling, or that is not low on the clock the channel stops. Decode faults show within one read of the affected address, either as nonzero data from a hole or as a changed neighbour register.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // register select taken from byte-address bits [3:2] inside a channel window
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  localparam int RUN_BIT = 0;  // run bit position in the control word
  localparam int PSC_LSB = 2;  // prescaler field starts here
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PSC_W      = 14,
  parameter bit HAS_MASTER = 1'b1,
  parameter int MASTER_OFS = 'h3C
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_CH-1:0]             ch_en,
  output logic [NUM_CH-1:0][PSC_W-1:0]  ch_psc,
  output logic [NUM_CH-1:0][CNT_W-1:0]  ch_duty,
  output logic [NUM_CH-1:0][CNT_W-1:0]  ch_period,
  output logic                          master_en
);
  localparam int CH_W = ADDR_W - 4;
  localparam logic [CH_W:0]     NCH_L = (CH_W+1)'(NUM_CH);
  localparam logic [ADDR_W-1:0] MST_A = ADDR_W'(MASTER_OFS);

  logic [CH_W-1:0]   a_ch;
  reg_sel_e          a_sel;
  logic              a_ok;
  logic              hit_master;
  logic [DATA_W-1:0] rd_val;

  assign a_ch       = bus_addr[ADDR_W-1:4];
  assign a_sel      = reg_sel_e'(bus_addr[3:2]);
  assign a_ok       = (bus_addr[1:0] == 2'b00) && ({1'b0, a_ch} < NCH_L);
  assign hit_master = HAS_MASTER && (bus_addr == MST_A);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_en[c]     <= 1'b0;
        ch_psc[c]    <= '0;
        ch_duty[c]   <= '0;
        ch_period[c] <= '0;
      end else if (bus_wr && a_ok && (a_ch == CH_W'(c))) begin
        case (a_sel)
          SEL_CTRL: begin
            ch_en[c]  <= bus_wdata[RUN_BIT];
            ch_psc[c] <= bus_wdata[PSC_LSB +: PSC_W];
          end
          SEL_DUTY:   ch_duty[c]   <= bus_wdata[CNT_W-1:0];
          SEL_PERIOD: ch_period[c] <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  if (HAS_MASTER) begin : g_master
    logic master_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    master_q <= 1'b0;
      else if (bus_wr && hit_master) master_q <= bus_wdata[0];
    end
    assign master_en = master_q;
  end else begin : g_no_master
    assign master_en = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (a_ok && (a_ch == CH_W'(c))) begin
        case (a_sel)
          SEL_CTRL: begin
            rd_val[RUN_BIT]           = ch_en[c];
            rd_val[PSC_LSB +: PSC_W]  = ch_psc[c];
          end
          SEL_DUTY:   rd_val[CNT_W-1:0] = ch_duty[c];
          SEL_PERIOD: rd_val[CNT_W-1:0] = ch_period[c];
          default: ;
        endcase
      end
    end
    if (hit_master) rd_val[0] = master_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic [CNT_W-1:0] cfg_period,
  output logic             pwm_o,
  output logic             start_o,
  output logic             tick_o,
  output logic             wrap_o
);
  logic             started_q;
  logic [PSC_W-1:0] psc_cnt_q, act_psc_q;
  logic [CNT_W-1:0] tick_cnt_q, act_duty_q, act_period_q;

  // last tick of a cycle; a zero cycle count wraps on every tick
  function automatic logic last_tick(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] per);
    return (per == '0) || (cnt == per - CNT_W'(1));
  endfunction

  // output level within a cycle; duty >= period stays high since cnt < period
  function automatic logic level(input logic [CNT_W-1:0] cnt,
                                 input logic [CNT_W-1:0] duty,
                                 input logic [CNT_W-1:0] per);
    return (per != '0) && (cnt < duty);
  endfunction

  assign start_o = run & ~started_q;
  assign tick_o  = run & started_q & (psc_cnt_q == act_psc_q);
  assign wrap_o  = tick_o & last_tick(tick_cnt_q, act_period_q);
  assign pwm_o   = run & started_q & level(tick_cnt_q, act_duty_q, act_period_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q    <= 1'b0;
      psc_cnt_q    <= '0;
      tick_cnt_q   <= '0;
      act_psc_q    <= '0;
      act_duty_q   <= '0;
      act_period_q <= '0;
    end else if (!run) begin
      started_q  <= 1'b0;
      psc_cnt_q  <= '0;
      tick_cnt_q <= '0;
    end else if (!started_q) begin
      started_q    <= 1'b1;
      psc_cnt_q    <= '0;
      tick_cnt_q   <= '0;
      act_psc_q    <= cfg_psc;
      act_duty_q   <= cfg_duty;
      act_period_q <= cfg_period;
    end else if (tick_o) begin
      psc_cnt_q <= '0;
      if (wrap_o) begin
        tick_cnt_q   <= '0;
        act_psc_q    <= cfg_psc;
        act_duty_q   <= cfg_duty;
        act_period_q <= cfg_period;
      end else begin
        tick_cnt_q <= tick_cnt_q + CNT_W'(1);
      end
    end else begin
      psc_cnt_q <= psc_cnt_q + PSC_W'(1);
    end
  end
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top #(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PSC_W      = 14,
  parameter bit HAS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]             ch_en;
  logic [NUM_CH-1:0][PSC_W-1:0]  ch_psc;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_duty;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_period;
  logic                          master_en;
  // named event wires for the checker
  logic [NUM_CH-1:0]             run_vec, start_vec, tick_vec, wrap_vec;

  pwm_bank_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .PSC_W(PSC_W), .HAS_MASTER(HAS_MASTER), .MASTER_OFS('h3C)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ch_en(ch_en), .ch_psc(ch_psc), .ch_duty(ch_duty),
    .ch_period(ch_period), .master_en(master_en)
  );

  assign run_vec = ch_en & {NUM_CH{master_en}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_bank_chan #(.CNT_W(CNT_W), .PSC_W(PSC_W)) chan_i (
      .clk(clk), .rst_n(rst_n), .run(run_vec[c]),
      .cfg_psc(ch_psc[c]), .cfg_duty(ch_duty[c]), .cfg_period(ch_period[c]),
      .pwm_o(pwm_out[c]), .start_o(start_vec[c]),
      .tick_o(tick_vec[c]), .wrap_o(wrap_vec[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic              master_en,
  input logic [NUM_CH-1:0] run_vec,
  input logic [NUM_CH-1:0] start_vec,
  input logic [NUM_CH-1:0] tick_vec,
  input logic [NUM_CH-1:0] wrap_vec
);
  a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  a_r8_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> pwm_out == '0);

  a_r9_reset_low: assert property (@(posedge clk)
    !rst_n |-> pwm_out == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r6_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run_vec[c] |-> !pwm_out[c]);

    a_r4_rise_at_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[c]) |-> $past(wrap_vec[c] || start_vec[c]));

    a_r7_steady_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      run_vec[c] && !start_vec[c] && !tick_vec[c] |=> (!run_vec[c] || $stable(pwm_out[c])));
  end
endmodule

bind pwm_bank_top pwm_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pwm_out(pwm_out), .master_en(master_en), .run_vec(run_vec),
  .start_vec(start_vec), .tick_vec(tick_vec), .wrap_vec(wrap_vec)
);

// File: tb/pwm_bank_top_tb_top.sv
module pwm_bank_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];
  logic     rd_seen_q = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_bank_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  // driver: pushes the expected value, the monitor compares it
  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    sb_q.push_back('{exp: exp, tag: tag});
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  always @(posedge clk) rd_seen_q <= bus_rd;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_seen_q) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2 unexpected read data", bus_rdata, 32'h0);
        end else begin
          rd_item_t it;
          it = sb_q.pop_front();
          check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
        end
      end else begin
        check(bus_rdata === 32'h0, "R2 idle rdata", bus_rdata, 32'h0);
      end
    end
  end

  task automatic measure(input int ch, input int exp_hi, input int exp_per, input string tag);
    int hi = 0;
    int lo = 0;
    int g  = 0;
    while (pwm_out[ch] !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
    while (pwm_out[ch] !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
    while (pwm_out[ch] === 1'b1 && g < 4000) begin hi++; @(negedge clk); g++; end
    while (pwm_out[ch] === 1'b0 && g < 4000) begin lo++; @(negedge clk); g++; end
    check(hi == exp_hi, {tag, " high clocks"}, 32'(hi), 32'(exp_hi));
    check(hi + lo == exp_per, {tag, " cycle clocks"}, 32'(hi + lo), 32'(exp_per));
  endtask

  task automatic hold_check(input int ch, input logic v, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch] !== v) bad++;
      @(negedge clk);
    end
    check(bad == 0, tag, 32'(bad), 32'h0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL R4 watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(pwm_out === 4'h0, "R9 outputs low in reset", 32'(pwm_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state of every register
    for (int c = 0; c < 4; c++) begin
      bus_read(8'(c * 16),     32'h0, "R9 control after reset");
      bus_read(8'(c * 16 + 4), 32'h0, "R9 duty after reset");
      bus_read(8'(c * 16 + 8), 32'h0, "R9 period after reset");
    end
    bus_read(8'h3C, 32'h0, "R9 gate after reset");
    check(pwm_out === 4'h0, "R9 outputs low after reset", 32'(pwm_out), 32'h0);

    // R1: field layout and readback of channel 2
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, 32'h0000_FFFD, "R1 control readback");
    bus_write(8'h24, 32'hABCD_1234);
    bus_read(8'h24, 32'h0000_1234, "R1 duty readback");
    bus_write(8'h28, 32'h5555_AAAA);
    bus_read(8'h28, 32'h0000_AAAA, "R1 period readback");
    bus_write(8'h20, 32'h0);

    // R8: channel 0 enabled but gate clear
    bus_write(8'h04, 32'd4);
    bus_write(8'h08, 32'd10);
    bus_write(8'h00, 32'h1);
    hold_check(0, 1'b0, 40, "R8 gate clear holds low");
    bus_read(8'h3C, 32'h0, "R8 gate reads clear");
    bus_write(8'h3C, 32'h1);
    check(pwm_out[0] === 1'b0, "R6 low on start clock", 32'(pwm_out[0]), 32'h0);
    @(negedge clk);
    check(pwm_out[0] === 1'b1, "R6 high after start", 32'(pwm_out[0]), 32'h1);
    bus_read(8'h3C, 32'h1, "R8 gate reads set");
    measure(0, 4, 10, "R4 ch0 p0 d4 n10");
    bus_read(8'h00, 32'h1, "R1 control keeps run bit");

    // R4: prescaled channel 1, p=2 d=3 n=5
    bus_write(8'h14, 32'd3);
    bus_write(8'h18, 32'd5);
    bus_write(8'h10, 32'h9);
    measure(1, 9, 15, "R4 ch1 p2 d3 n5");

    // R7: duty change mid-cycle waits for the cycle end
    begin
      int g = 0;
      int hi = 0;
      while (pwm_out[0] !== 1'b0 && g < 100) begin @(negedge clk); g++; end
      while (pwm_out[0] !== 1'b1 && g < 100) begin @(negedge clk); g++; end
      bus_write(8'h04, 32'd8);
      while (pwm_out[0] === 1'b1 && g < 100) begin hi++; @(negedge clk); g++; end
      check(hi == 2, "R7 current cycle keeps old duty", 32'(hi), 32'd2);
    end
    measure(0, 8, 10, "R7 new duty in next cycle");

    // R5: duty >= period, period zero, duty zero on channel 3
    bus_write(8'h34, 32'd20);
    bus_write(8'h38, 32'd6);
    bus_write(8'h30, 32'h1);
    repeat (3) @(negedge clk);
    hold_check(3, 1'b1, 60, "R5 duty above period stays high");
    bus_write(8'h38, 32'd0);
    repeat (10) @(negedge clk);
    hold_check(3, 1'b0, 40, "R5 zero period stays low");
    bus_write(8'h38, 32'd6);
    bus_write(8'h34, 32'd0);
    repeat (10) @(negedge clk);
    hold_check(3, 1'b0, 40, "R5 zero duty stays low");

    // R6: stop and restart channel 1
    bus_write(8'h10, 32'h8);
    check(pwm_out[1] === 1'b0, "R6 low once stopped", 32'(pwm_out[1]), 32'h0);
    hold_check(1, 1'b0, 30, "R6 stays low while stopped");
    bus_read(8'h10, 32'h8, "R1 prescaler kept with run bit clear");
    bus_write(8'h10, 32'h9);
    check(pwm_out[1] === 1'b0, "R6 low on restart clock", 32'(pwm_out[1]), 32'h0);
    @(negedge clk);
    check(pwm_out[1] === 1'b1, "R6 fresh cycle starts high", 32'(pwm_out[1]), 32'h1);
    measure(1, 9, 15, "R6 cycle after restart");

    // R3: holes ignore writes and read zero
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_read(8'h0C, 32'h0, "R3 spare offset reads zero");
    bus_write(8'h40, 32'h0);
    bus_read(8'h40, 32'h0, "R3 beyond channels reads zero");
    bus_write(8'h01, 32'h0);
    bus_read(8'h01, 32'h0, "R3 unaligned reads zero");
    bus_read(8'h00, 32'h1, "R3 control untouched by hole writes");
    bus_read(8'h04, 32'd8, "R3 duty untouched by hole writes");

    // R8: clearing the gate drops every output
    bus_write(8'h3C, 32'h0);
    check(pwm_out === 4'h0, "R8 gate clear drops outputs", 32'(pwm_out), 32'h0);
    hold_check(1, 1'b0, 20, "R8 channel 1 held low");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2 every read answered", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule